// File: doc/BRIEF.md
# Preamble and Address Packet Receiver

This block sits behind a bit-recovery stage. It receives one recovered data bit per `bit_valid` strobe and hunts for a 16-bit synchronisation word. Software supplies that word as two bytes, and the transmitter uses the same value. Once the word is found, the block counts header bytes. It compares a network identifier byte and a node identifier byte, each at its own configured header position, and either comparison can be switched off. A failed comparison sends the receiver back to hunting and never raises lock.

When every enabled identifier matches, the receiver declares lock and pulses a lock-in event. It then packs the following bits, most significant bit first, into payload bytes and presents each byte with a one-cycle strobe. After the programmed number of payload bytes it pulses a lock-out event, drops lock and resumes hunting. While lock is held, the raw carrier-sense input is masked, because a packet has already been identified.

Top module: `sar_rx`

## Requirements
- R1: The synchronisation word is `{pre_hi, pre_lo}`. `pre_hi` bit 7 is the earliest bit on the line. A match is found when the last 16 sampled bits equal this word. At least 16 bits must have been sampled since reset, since an abandoned header or since a completed packet.
- R2: A bit is sampled only in a cycle where `bit_valid` is 1. In cycles where `bit_valid` is 0, `bit_in` has no effect, and `locked` and `byte_valid` do not change to reflect a new bit.
- R3: Header bytes are numbered from 0 starting right after the synchronisation word. When `net_en` is 1, byte `net_pos` must equal `net_id`. When `node_en` is 1, byte `node_pos` must equal `node_id`, and `node_pos` is greater than `net_pos` when both are enabled. Any mismatch returns the receiver to hunting without raising `locked`.
- R4: `locked` rises in the cycle after the sampled bit that completes the last enabled identifier byte. That byte is `node_pos` when `node_en` is 1, otherwise `net_pos`. When both filters are off, `locked` rises in the cycle after the final synchronisation bit.
- R5: `lock_in` is a one-cycle pulse in the cycle in which `locked` rises.
- R6: Payload bits start right after the lock point. They are packed MSB first, and each completed byte appears on `byte_data` with a one-cycle `byte_valid`. Header bytes are never emitted.
- R7: When the payload byte number `pkt_len` completes, `lock_out` pulses together with that byte's `byte_valid`, and `locked` falls in the same cycle. A `pkt_len` of 0 means 256 bytes.
- R8: `cs_out` equals `cs_raw` while `locked` is 0 and is 0 while `locked` is 1.
- R9: A synchronous reset (`rst` = 1) clears `locked`, `lock_in`, `lock_out` and `byte_valid` and returns the receiver to hunting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| bit_valid | input | 1 | Strobe marking a recovered bit |
| bit_in | input | 1 | Recovered bit value |
| cs_raw | input | 1 | Unfiltered carrier-sense indication |
| pre_lo | input | 8 | Synchronisation word, later byte |
| pre_hi | input | 8 | Synchronisation word, earlier byte |
| net_id | input | 8 | Expected network identifier |
| node_id | input | 8 | Expected node identifier |
| net_en | input | 1 | Enable network identifier check |
| node_en | input | 1 | Enable node identifier check |
| net_pos | input | 4 | Header byte index of network identifier |
| node_pos | input | 4 | Header byte index of node identifier |
| pkt_len | input | 8 | Payload length in bytes (0 means 256) |
| locked | output | 1 | Packet identified and being received |
| lock_in | output | 1 | One-cycle pulse on lock |
| lock_out | output | 1 | One-cycle pulse at packet end |
| byte_valid | output | 1 | Payload byte strobe |
| byte_data | output | 8 | Payload byte |
| cs_out | output | 1 | Carrier sense masked by lock |

## Verification
Directed packets cover four cases: both filters matching, a wrong network byte, a wrong node byte, and both filters off. These cases separate the staged lock point from a plain word match and show that a rejected header never emits bytes. A node-only packet and a 256-byte packet expose an off-by-one in the position and length counters. Random noise ahead of the word, random idle gaps with toggling `bit_in`, and randomly corrupted identifiers then show that only strobed bits count and that hunting restarts on fresh bits. A reset in the middle of a packet confirms that the receiver goes back to hunting.

// File: rtl/sar_pkg.sv
package sar_pkg;
    typedef enum logic [1:0] {
        ST_HUNT = 2'd0,
        ST_HDR  = 2'd1,
        ST_BODY = 2'd2
    } rx_state_e;
endpackage

// File: rtl/sar_pre_corr.sv
module sar_pre_corr #(
    parameter int W = 16
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         clr,
    input  logic         bit_valid,
    input  logic         bit_in,
    input  logic [W-1:0] pattern,
    output logic         hit
);
    localparam int CW = $clog2(W + 1);

    typedef struct packed {
        logic [W-1:0]  sr;
        logic [CW-1:0] fill;
    } corr_t;

    corr_t cur_q, nxt_d;
    logic [W-1:0] window;

    assign window = {cur_q.sr[W-2:0], bit_in};
    assign hit    = bit_valid && !clr && (cur_q.fill >= CW'(W - 1)) && (window == pattern);

    always_comb begin
        nxt_d = cur_q;
        if (clr) begin
            nxt_d.fill = '0;
        end else if (bit_valid) begin
            nxt_d.sr = window;
            if (cur_q.fill != CW'(W)) begin
                nxt_d.fill = cur_q.fill + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/sar_byte_pack.sv
module sar_byte_pack #(
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          clr,
    input  logic          bit_valid,
    input  logic          bit_in,
    output logic          done,
    output logic [BW-1:0] data
);
    localparam int CNT_W = $clog2(BW);

    typedef struct packed {
        logic [BW-1:0]    sh;
        logic [CNT_W-1:0] cnt;
    } pack_t;

    pack_t cur_q, nxt_d;

    assign data = {cur_q.sh[BW-2:0], bit_in};
    assign done = bit_valid && !clr && (cur_q.cnt == CNT_W'(BW - 1));

    always_comb begin
        nxt_d = cur_q;
        if (clr) begin
            nxt_d.cnt = '0;
        end else if (bit_valid) begin
            nxt_d.sh  = data;
            nxt_d.cnt = done ? '0 : cur_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q <= '0;
        end else begin
            cur_q <= nxt_d;
        end
    end
endmodule

// File: rtl/sar_id_match.sv
module sar_id_match #(
    parameter int BW = 8,
    parameter int PW = 4
) (
    input  logic [PW-1:0] idx,
    input  logic [BW-1:0] hdr_byte,
    input  logic [BW-1:0] net_id,
    input  logic [BW-1:0] node_id,
    input  logic          net_en,
    input  logic          node_en,
    input  logic [PW-1:0] net_pos,
    input  logic [PW-1:0] node_pos,
    output logic          reject,
    output logic          last,
    output logic          no_hdr
);
    logic at_net, at_node;

    always_comb begin
        at_net  = net_en  && (idx == net_pos);
        at_node = node_en && (idx == node_pos);
        reject  = (at_net && (hdr_byte != net_id)) || (at_node && (hdr_byte != node_id));
        last    = node_en ? at_node : at_net;
        no_hdr  = !net_en && !node_en;
    end
endmodule

// File: rtl/sar_rx.sv
module sar_rx
    import sar_pkg::*;
#(
    parameter int BYTE_W = 8,
    parameter int POS_W  = 4,
    parameter int LEN_W  = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bit_valid,
    input  logic              bit_in,
    input  logic              cs_raw,
    input  logic [BYTE_W-1:0] pre_lo,
    input  logic [BYTE_W-1:0] pre_hi,
    input  logic [BYTE_W-1:0] net_id,
    input  logic [BYTE_W-1:0] node_id,
    input  logic              net_en,
    input  logic              node_en,
    input  logic [POS_W-1:0]  net_pos,
    input  logic [POS_W-1:0]  node_pos,
    input  logic [LEN_W-1:0]  pkt_len,
    output logic              locked,
    output logic              lock_in,
    output logic              lock_out,
    output logic              byte_valid,
    output logic [BYTE_W-1:0] byte_data,
    output logic              cs_out
);
    localparam int PRE_W = 2 * BYTE_W;

    typedef struct packed {
        rx_state_e         st;
        logic [POS_W-1:0]  hidx;
        logic [LEN_W-1:0]  cnt;
        logic              locked;
        logic              lock_in;
        logic              lock_out;
        logic              bval;
        logic [BYTE_W-1:0] data;
    } rx_regs_t;

    rx_regs_t cur_q, nxt_d;

    logic              pre_hit;
    logic              abandon;
    logic              pack_clr;
    logic              byte_done;
    logic [BYTE_W-1:0] byte_now;
    logic              id_reject, id_last, id_none;

    assign pack_clr = (cur_q.st == ST_HUNT);

    sar_pre_corr #(.W(PRE_W)) u_corr (
        .clk      (clk),
        .rst      (rst),
        .clr      (abandon),
        .bit_valid(bit_valid),
        .bit_in   (bit_in),
        .pattern  ({pre_hi, pre_lo}),
        .hit      (pre_hit)
    );

    sar_byte_pack #(.BW(BYTE_W)) u_pack (
        .clk      (clk),
        .rst      (rst),
        .clr      (pack_clr),
        .bit_valid(bit_valid),
        .bit_in   (bit_in),
        .done     (byte_done),
        .data     (byte_now)
    );

    sar_id_match #(.BW(BYTE_W), .PW(POS_W)) u_idm (
        .idx     (cur_q.hidx),
        .hdr_byte(byte_now),
        .net_id  (net_id),
        .node_id (node_id),
        .net_en  (net_en),
        .node_en (node_en),
        .net_pos (net_pos),
        .node_pos(node_pos),
        .reject  (id_reject),
        .last    (id_last),
        .no_hdr  (id_none)
    );

    always_comb begin
        nxt_d          = cur_q;
        nxt_d.lock_in  = 1'b0;
        nxt_d.lock_out = 1'b0;
        nxt_d.bval     = 1'b0;
        abandon        = 1'b0;
        unique case (cur_q.st)
            ST_HUNT: begin
                if (pre_hit) begin
                    nxt_d.hidx = '0;
                    nxt_d.cnt  = '0;
                    if (id_none) begin
                        nxt_d.st      = ST_BODY;
                        nxt_d.locked  = 1'b1;
                        nxt_d.lock_in = 1'b1;
                    end else begin
                        nxt_d.st = ST_HDR;
                    end
                end
            end
            ST_HDR: begin
                if (byte_done) begin
                    if (id_reject) begin
                        nxt_d.st = ST_HUNT;
                        abandon  = 1'b1;
                    end else if (id_last) begin
                        nxt_d.st      = ST_BODY;
                        nxt_d.locked  = 1'b1;
                        nxt_d.lock_in = 1'b1;
                    end else begin
                        nxt_d.hidx = cur_q.hidx + 1'b1;
                    end
                end
            end
            ST_BODY: begin
                if (byte_done) begin
                    nxt_d.bval = 1'b1;
                    nxt_d.data = byte_now;
                    if (LEN_W'(cur_q.cnt + 1'b1) == pkt_len) begin
                        nxt_d.lock_out = 1'b1;
                        nxt_d.locked   = 1'b0;
                        nxt_d.st       = ST_HUNT;
                        abandon        = 1'b1;
                    end else begin
                        nxt_d.cnt = cur_q.cnt + 1'b1;
                    end
                end
            end
            default: begin
                nxt_d.st     = ST_HUNT;
                nxt_d.locked = 1'b0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q    <= '0;
            cur_q.st <= ST_HUNT;
        end else begin
            cur_q <= nxt_d;
        end
    end

    assign locked     = cur_q.locked;
    assign lock_in    = cur_q.lock_in;
    assign lock_out   = cur_q.lock_out;
    assign byte_valid = cur_q.bval;
    assign byte_data  = cur_q.data;
    assign cs_out     = cs_raw && !cur_q.locked;

    AST_LOCKIN_ON_RISE: assert property (@(posedge clk) disable iff (rst) $rose(locked) |-> lock_in); // R5
    AST_LOCKOUT_WITH_BYTE: assert property (@(posedge clk) disable iff (rst) lock_out |-> byte_valid); // R7
    AST_LOCKOUT_DROPS: assert property (@(posedge clk) disable iff (rst) lock_out |-> !locked); // R7
    AST_CS_MASKED: assert property (@(posedge clk) disable iff (rst) locked |-> !cs_out); // R8
    AST_BYTE_IN_PACKET: assert property (@(posedge clk) disable iff (rst) byte_valid |-> (locked || lock_out)); // R6
    AST_IDLE_NO_BYTE: assert property (@(posedge clk) disable iff (rst) !bit_valid |=> !byte_valid); // R2
    AST_IDLE_LOCK_HOLD: assert property (@(posedge clk) disable iff (rst) !bit_valid |=> $stable(locked)); // R2
endmodule

// File: tb/sar_rx_tb.sv
module sar_rx_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bit_valid = 1'b0, bit_in = 1'b0, cs_raw = 1'b0;
    logic [7:0] pre_lo = 8'h00, pre_hi = 8'h00, net_id = 8'h00, node_id = 8'h00;
    logic       net_en = 1'b0, node_en = 1'b0;
    logic [3:0] net_pos = 4'd0, node_pos = 4'd0;
    logic [7:0] pkt_len = 8'd1;
    logic       locked, lock_in, lock_out, byte_valid, cs_out;
    logic [7:0] byte_data;

    always #2.5 clk = ~clk;

    sar_rx u_dut (
        .clk(clk), .rst(rst), .bit_valid(bit_valid), .bit_in(bit_in), .cs_raw(cs_raw),
        .pre_lo(pre_lo), .pre_hi(pre_hi), .net_id(net_id), .node_id(node_id),
        .net_en(net_en), .node_en(node_en), .net_pos(net_pos), .node_pos(node_pos),
        .pkt_len(pkt_len), .locked(locked), .lock_in(lock_in), .lock_out(lock_out),
        .byte_valid(byte_valid), .byte_data(byte_data), .cs_out(cs_out)
    );

    int    n_chk = 0, n_bad = 0;
    string cur_req = "R9";
    bit    finished = 1'b0;

    // bench reference state
    logic [15:0] m_sr;
    int          m_fill, m_st, m_hidx, m_bc, m_cnt;
    logic [7:0]  m_byte;
    logic        e_lk, e_li, e_lo, e_bv;
    logic [7:0]  e_bd;

    task automatic model_clear();
        m_sr = '0; m_fill = 0; m_st = 0; m_hidx = 0; m_bc = 0; m_cnt = 0; m_byte = '0;
        e_lk = 0; e_li = 0; e_lo = 0; e_bv = 0; e_bd = '0;
    endtask

    task automatic model_bit(input logic b);
        logic [15:0] win;
        logic        drop, rej, lst;
        int          need;
        drop = 1'b0;
        e_li = 0; e_lo = 0; e_bv = 0;
        win  = {m_sr[14:0], b};
        if (m_st == 0) begin
            m_bc = 0;
            if (m_fill >= 15 && win == {pre_hi, pre_lo}) begin        // R1
                m_hidx = 0; m_cnt = 0;
                if (!net_en && !node_en) begin m_st = 2; e_lk = 1; e_li = 1; end
                else m_st = 1;
            end
        end else begin
            m_byte = {m_byte[6:0], b};
            m_bc++;
            if (m_bc == 8) begin
                m_bc = 0;
                if (m_st == 1) begin                                   // R3
                    rej = (net_en && m_hidx == int'(net_pos) && m_byte != net_id) ||
                          (node_en && m_hidx == int'(node_pos) && m_byte != node_id);
                    lst = node_en ? (m_hidx == int'(node_pos)) : (net_en && m_hidx == int'(net_pos));
                    if (rej) begin m_st = 0; drop = 1; end
                    else if (lst) begin m_st = 2; e_lk = 1; e_li = 1; end
                    else m_hidx++;
                end else begin
                    e_bv = 1; e_bd = m_byte; m_cnt++;
                    need = (pkt_len == 0) ? 256 : int'(pkt_len);
                    if (m_cnt == need) begin e_lo = 1; e_lk = 0; m_st = 0; drop = 1; end
                end
            end
        end
        if (drop) m_fill = 0;
        else begin m_sr = win; if (m_fill < 16) m_fill++; end
    endtask

    task automatic compare();
        logic bad;
        #1;
        bad = 1'b0;
        n_chk++;
        if (locked !== e_lk) begin bad = 1; $display("FAIL %s R4 locked act=%0d exp=%0d", cur_req, locked, e_lk); end
        if (lock_in !== e_li) begin bad = 1; $display("FAIL %s R5 lock_in act=%0d exp=%0d", cur_req, lock_in, e_li); end
        if (lock_out !== e_lo) begin bad = 1; $display("FAIL %s R7 lock_out act=%0d exp=%0d", cur_req, lock_out, e_lo); end
        if (byte_valid !== e_bv) begin bad = 1; $display("FAIL %s R6 byte_valid act=%0d exp=%0d", cur_req, byte_valid, e_bv); end
        if (e_bv && byte_data !== e_bd) begin bad = 1; $display("FAIL %s R6 byte_data act=%02h exp=%02h", cur_req, byte_data, e_bd); end
        if (cs_out !== (cs_raw && !e_lk)) begin bad = 1; $display("FAIL %s R8 cs_out act=%0d exp=%0d", cur_req, cs_out, cs_raw && !e_lk); end
        if (bad) n_bad++;
    endtask

    // called at a falling edge; returns at a falling edge
    task automatic send_bit(input logic b, input int gap);
        bit_in = b; bit_valid = 1'b1; cs_raw = 1'($urandom);
        model_bit(b);
        @(negedge clk);
        bit_valid = 1'b0; bit_in = 1'($urandom); cs_raw = 1'($urandom);
        compare();
        for (int g = 0; g < gap; g++) begin
            e_li = 0; e_lo = 0; e_bv = 0;
            @(negedge clk);
            bit_in = 1'($urandom); cs_raw = 1'($urandom);      // R2 noise on idle cycles
            compare();
        end
    endtask

    task automatic send_byte(input logic [7:0] v, input int maxgap);
        for (int i = 7; i >= 0; i--) send_bit(v[i], (maxgap == 0) ? 0 : int'($urandom_range(0, maxgap)));
    endtask

    task automatic send_pre(input int maxgap);
        send_byte(pre_hi, maxgap);
        send_byte(pre_lo, maxgap);
    endtask

    task automatic send_hdr(input int corrupt_at, input int maxgap);
        int hl;
        logic [7:0] v;
        hl = node_en ? int'(node_pos) + 1 : (net_en ? int'(net_pos) + 1 : 0);
        for (int i = 0; i < hl; i++) begin
            if (net_en && i == int'(net_pos)) v = net_id;
            else if (node_en && i == int'(node_pos)) v = node_id;
            else v = 8'($urandom);
            if (i == corrupt_at) v = v ^ 8'h10;
            send_byte(v, maxgap);
        end
    endtask

    task automatic send_payload(input int n, input int maxgap);
        for (int i = 0; i < n; i++) send_byte(8'($urandom), maxgap);
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1; bit_valid = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        model_clear();
        cur_req = "R9";
        compare();                                              // R9 reset state
    endtask

    task automatic set_cfg(input logic [15:0] pat, input logic ne, input logic [3:0] np,
                           input logic de, input logic [3:0] dp, input logic [7:0] len);
        pre_hi = pat[15:8]; pre_lo = pat[7:0];
        net_en = ne; net_pos = np; node_en = de; node_pos = dp; pkt_len = len;
        net_id = 8'h5A; node_id = 8'hC3;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog R9 act=timeout exp=done");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        model_clear();
        repeat (2) @(negedge clk);
        do_reset();

        // R1 R4 R5 R6 R7: both filters, ids at 1 and 3
        cur_req = "R1";
        set_cfg(16'hA5F0, 1, 4'd1, 1, 4'd3, 8'd5);
        send_pre(0); send_hdr(-1, 0); send_payload(5, 0);
        repeat (3) send_bit(1'b0, 0);

        // R3: network byte wrong, then a clean packet on fresh bits
        cur_req = "R3";
        send_pre(0); send_hdr(1, 0); send_payload(3, 0);
        send_pre(0); send_hdr(-1, 0); send_payload(5, 0);

        // R3: node byte wrong
        send_pre(0); send_hdr(3, 0); send_payload(2, 0);

        // R4: both filters off, lock right after the word
        cur_req = "R4";
        set_cfg(16'h3C96, 0, 4'd0, 0, 4'd0, 8'd3);
        send_pre(0); send_payload(3, 0);

        // R4: node filter only at position 0
        set_cfg(16'hE10F, 0, 4'd5, 1, 4'd0, 8'd2);
        send_pre(1); send_hdr(-1, 1); send_payload(2, 1);

        // R7: length 0 means 256 bytes
        cur_req = "R7";
        set_cfg(16'h1D2B, 1, 4'd0, 0, 4'd0, 8'd0);
        send_pre(0); send_hdr(-1, 0); send_payload(256, 0);
        send_bit(1'b1, 2);

        // R2: idle gaps with noisy bit_in
        cur_req = "R2";
        set_cfg(16'hB00B, 1, 4'd2, 1, 4'd4, 8'd4);
        send_pre(3); send_hdr(-1, 3); send_payload(4, 3);

        // R9: reset while locked
        cur_req = "R9";
        send_pre(0); send_hdr(-1, 0); send_payload(2, 0);
        do_reset();
        send_pre(0); send_hdr(-1, 0); send_payload(4, 0);

        // R8 and random mixes
        cur_req = "R8";
        for (int it = 0; it < 30; it++) begin
            logic ne, de;
            logic [3:0] np, dp;
            int cor, noise;
            ne = 1'($urandom); de = 1'($urandom);
            np = 4'($urandom_range(0, 3));
            dp = ne ? np + 4'($urandom_range(1, 3)) : 4'($urandom_range(0, 3));
            set_cfg(16'($urandom), ne, np, de, dp, 8'($urandom_range(1, 12)));
            noise = $urandom_range(0, 40);
            for (int k = 0; k < noise; k++) send_bit(1'($urandom), int'($urandom_range(0, 1)));
            cor = ($urandom_range(0, 3) == 0) ? int'($urandom_range(0, 6)) : -1;
            send_pre(1); send_hdr(cor, 1); send_payload(int'(pkt_len), 1);
        end

        finished = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule